// File: doc/BRIEF.md
# Selectable Periodic Rate Generator

This block turns a 32768 Hz clock-enable pulse train into two products: a square-wave level for an output pin, and a one-cycle periodic event pulse for downstream interrupt-flag logic. A 4-bit rate code picks the division ratio. Most codes select a power-of-two fraction of the timebase. The decoding is irregular: two low codes stand in for two higher ones, and code zero stops everything.

Three enable inputs shape the result. The square-wave enable gates the pin. The periodic enable gates the event pulse. A fast-clock override forces the pin to follow the 32768 Hz timebase whatever the code is, and while the override is on it suppresses periodic events. The divider phase restarts whenever the rate code changes, so the first period after a change is a full one.

Top module: `prg_top`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `sqw_out` and `periodic_evt` are both 0.
- R2: For a rate code c from 3 to 15, the square wave has a period of 2^(c-1) timebase ticks, which gives 32768/2^(c-1) Hz: code 3 is 8192 Hz and code 15 is 2 Hz. The wave is low for the first half of each period and high for the second half, counted from the last code change.
- R3: Code 1 behaves exactly like code 8 (a period of 128 ticks), and code 2 behaves exactly like code 9 (a period of 256 ticks).
- R4: Code 0 produces no periodic events. While the override is off, code 0 also holds `sqw_out` at 0.
- R5: While `fast_en` is 1, `sqw_out` is 1 in the clock cycle after each cycle in which `tick_32k` is 1, and 0 otherwise, whatever the rate code and `sqw_en` are.
- R6: While `fast_en` is 1, `periodic_evt` stays 0.
- R7: When both `sqw_en` and `fast_en` are 0, `sqw_out` is 0.
- R8: With `pie_en` = 1, the override off and a nonzero code, `periodic_evt` pulses for exactly one cycle once per period. The pulse comes in the cycle in which the square wave rises, which is after tick number P/2 + n·P since the last code change.
- R9: Any change of the rate code restarts the phase. The wave goes low, and the next rising edge and event come P/2 ticks after the change.
- R10: With `pie_en` = 0, `periodic_evt` stays 0, while the square wave keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable pulse at 32768 Hz |
| rate_code | input | 4 | Rate select code |
| sqw_en | input | 1 | Square-wave output enable |
| fast_en | input | 1 | 32768 Hz override enable |
| pie_en | input | 1 | Periodic event enable |
| sqw_out | output | 1 | Square-wave pin level |
| periodic_evt | output | 1 | One-cycle periodic event pulse |

## Verification
The bench builds the block with its default divider width of 14 bits. That width makes the slowest code (15, a period of 16384 ticks) reachable, and the bench runs that code far enough to see its first rising edge. Ticks arrive every second clock, so the slow rates fit in the cycle budget. The bench also covers the aliased codes 1 and 2 against their 128-tick and 256-tick periods, and the override's effect on both the pin and the events. It changes the code part-way through a period to show that the phase restarts.

// File: rtl/prg_pkg.sv
package prg_pkg;

    localparam int RATE_W  = 4;
    localparam int DIV_W   = 14;
    localparam int SHIFT_W = $clog2(DIV_W + 1);

    localparam logic [RATE_W-1:0] ALIAS_A_CODE  = RATE_W'(1);
    localparam logic [RATE_W-1:0] ALIAS_B_CODE  = RATE_W'(2);
    localparam logic [SHIFT_W-1:0] ALIAS_A_SHIFT = SHIFT_W'(7);
    localparam logic [SHIFT_W-1:0] ALIAS_B_SHIFT = SHIFT_W'(8);

    typedef struct packed {
        logic               active;
        logic [SHIFT_W-1:0] shift;
    } rate_sel_t;

    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic [RATE_W-1:0] code;
    } div_st_t;

    typedef struct packed {
        logic sqw;
        logic evt;
    } out_st_t;

    function automatic rate_sel_t decode_rate(input logic [RATE_W-1:0] code);
        rate_sel_t r;
        r.active = 1'b1;
        if (code == '0) begin
            r.active = 1'b0;
            r.shift  = '0;
        end else if (code == ALIAS_A_CODE) begin
            r.shift = ALIAS_A_SHIFT;
        end else if (code == ALIAS_B_CODE) begin
            r.shift = ALIAS_B_SHIFT;
        end else begin
            r.shift = SHIFT_W'(code - 1'b1);
        end
        return r;
    endfunction

endpackage

// File: rtl/prg_decode.sv
module prg_decode
    import prg_pkg::*;
(
    input  logic [RATE_W-1:0] code,
    output logic              active,
    output logic [DIV_W-1:0]  mask,
    output logic [DIV_W-1:0]  half
);
    rate_sel_t sel;

    always_comb begin
        sel    = decode_rate(code);
        active = sel.active;
        mask   = (DIV_W'(1) << sel.shift) - DIV_W'(1);
        half   = sel.active ? (DIV_W'(1) << (sel.shift - SHIFT_W'(1))) : '0;
    end

    always_comb begin
        AST_HALF_ONEHOT: assert (!active || $onehot(half)); // R2
    end
endmodule

// File: rtl/prg_divider.sv
module prg_divider
    import prg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] code,
    input  logic              active,
    input  logic [DIV_W-1:0]  mask,
    input  logic [DIV_W-1:0]  half,
    output logic              level_nxt,
    output logic              rise
);
    div_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.code = code;
        rise      = 1'b0;
        if (code != st_q.code) begin
            st_d.cnt = '0;
        end else if (active && tick) begin
            st_d.cnt = (st_q.cnt + DIV_W'(1)) & mask;
            rise     = ((st_q.cnt & mask) == (half - DIV_W'(1)));
        end
        level_nxt = active && (|(st_d.cnt & half));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PHASE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (code != st_q.code) |=> (st_q.cnt == '0)); // R9

    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!active) |=> (st_q.cnt == '0)); // R4
endmodule

// File: rtl/prg_top.sv
module prg_top
    import prg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [RATE_W-1:0] rate_code,
    input  logic              sqw_en,
    input  logic              fast_en,
    input  logic              pie_en,
    output logic              sqw_out,
    output logic              periodic_evt
);
    logic             active;
    logic [DIV_W-1:0] mask;
    logic [DIV_W-1:0] half;
    logic             level_nxt;
    logic             rise;
    out_st_t          out_d, out_q;

    prg_decode u_decode (
        .code   (rate_code),
        .active (active),
        .mask   (mask),
        .half   (half)
    );

    prg_divider u_divider (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_32k),
        .code      (rate_code),
        .active    (active),
        .mask      (mask),
        .half      (half),
        .level_nxt (level_nxt),
        .rise      (rise)
    );

    always_comb begin
        out_d = out_q;
        if (fast_en) begin
            out_d.sqw = tick_32k;
        end else if (sqw_en) begin
            out_d.sqw = level_nxt;
        end else begin
            out_d.sqw = 1'b0;
        end
        out_d.evt = rise && pie_en && !fast_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign sqw_out      = out_q.sqw;
    assign periodic_evt = out_q.evt;

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_evt |=> !periodic_evt); // R8

    AST_EVT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (pie_en && sqw_en && !fast_en && rise) |=> $rose(sqw_out)); // R8

    AST_FAST_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        fast_en |=> !periodic_evt); // R6

    AST_FAST_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fast_en |=> (sqw_out == $past(tick_32k))); // R5

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!sqw_en && !fast_en) |=> !sqw_out); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == '0 && !fast_en) |=> (!sqw_out && !periodic_evt)); // R4

    AST_NO_PIE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !pie_en |=> !periodic_evt); // R10
endmodule

// File: tb/tb_prg_top.sv
module tb_prg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_code = 4'd0;
    logic       sqw_en = 1'b0;
    logic       fast_en = 1'b0;
    logic       pie_en = 1'b0;
    logic       sqw_out;
    logic       periodic_evt;

    int    n_checks = 0;
    int    n_fail = 0;
    int    k = 0;
    int    exp_q[$];
    logic  last_tick = 1'b0;
    logic  chk = 1'b0;
    logic  exp_sqw;
    int    popped;
    string cur_req = "R1";
    logic [3:0] m_code = 4'd0;
    logic  m_sqe = 1'b0, m_fast = 1'b0, m_pie = 1'b0;

    always #10 clk = ~clk;

    prg_top dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_code(rate_code),
        .sqw_en(sqw_en), .fast_en(fast_en), .pie_en(pie_en),
        .sqw_out(sqw_out), .periodic_evt(periodic_evt)
    );

    function automatic int period_of(input logic [3:0] c);
        int eff;
        if (c == 4'd0) return 0;
        eff = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
        return 1 << (eff - 1);
    endfunction

    function automatic logic model_sqw();
        int p;
        if (m_fast) return last_tick;
        p = period_of(m_code);
        if (!m_sqe || p == 0) return 1'b0;
        return ((k % p) >= (p / 2));
    endfunction

    // monitor: compares the level every cycle and pops the expected events
    always @(negedge clk) begin
        if (chk) begin
            exp_sqw = model_sqw();
            n_checks++;
            if (sqw_out !== exp_sqw) begin
                n_fail++;
                $display("FAIL %s sqw_out k=%0d actual=%b expected=%b", cur_req, k, sqw_out, exp_sqw);
            end
            if (periodic_evt === 1'b1) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL %s unexpected event actual=k%0d expected=none", cur_req, k);
                end else begin
                    popped = exp_q.pop_front();
                    if (popped != k) begin
                        n_fail++;
                        $display("FAIL %s event tick actual=%0d expected=%0d", cur_req, k, popped);
                    end
                end
            end
        end
    end

    // driver: applies ticks and pushes the events the requirements predict
    task automatic do_tick();
        int p;
        tick_32k = 1'b1;
        @(posedge clk);
        k++;
        last_tick = 1'b1;
        p = period_of(m_code);
        if (m_pie && !m_fast && p != 0 && (k % p) == (p / 2)) exp_q.push_back(k);
        #1 tick_32k = 1'b0;
        @(posedge clk);
        last_tick = 1'b0;
        #1;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) do_tick();
    endtask

    task automatic set_cfg(input logic [3:0] c, input logic sqe, input logic fst,
                           input logic pie, input string req);
        rate_code = c; sqw_en = sqe; fast_en = fst; pie_en = pie;
        @(posedge clk);
        if (c != m_code) k = 0;
        m_code = c; m_sqe = sqe; m_fast = fst; m_pie = pie;
        last_tick = 1'b0;
        cur_req = req;
        #1;
    endtask

    task automatic seg_end(input string req);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing events actual=%0d expected=0 (next k=%0d)", req, exp_q.size(), exp_q[0]);
        end
        exp_q.delete();
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_checks++;
            if (sqw_out !== 1'b0 || periodic_evt !== 1'b0) begin
                n_fail++;
                $display("FAIL R1 reset outputs actual=%b%b expected=00", sqw_out, periodic_evt);
            end
        end
        @(posedge clk);
        #1 rst_n = 1'b1;
        chk = 1'b1;

        // R2 R8: fastest code, events at k = 2, 6, 10, ...
        set_cfg(4'd3, 1'b1, 1'b0, 1'b1, "R2");
        run_ticks(20);
        seg_end("R2");
        set_cfg(4'd6, 1'b1, 1'b0, 1'b1, "R8");
        run_ticks(70);
        seg_end("R8");
        // R3: aliased codes
        set_cfg(4'd1, 1'b1, 1'b0, 1'b1, "R3");
        run_ticks(200);
        seg_end("R3");
        set_cfg(4'd2, 1'b1, 1'b0, 1'b1, "R3");
        run_ticks(300);
        seg_end("R3");
        set_cfg(4'd10, 1'b1, 1'b0, 1'b1, "R2");
        run_ticks(600);
        seg_end("R2");
        // R2: slowest code, first rise after 8192 ticks
        set_cfg(4'd15, 1'b1, 1'b0, 1'b1, "R2");
        run_ticks(8200);
        seg_end("R2");
        // R4: code 0 silent
        set_cfg(4'd0, 1'b1, 1'b0, 1'b1, "R4");
        run_ticks(100);
        seg_end("R4");
        // R10: events off, wave on
        set_cfg(4'd4, 1'b1, 1'b0, 1'b0, "R10");
        run_ticks(50);
        seg_end("R10");
        // R7: wave disabled, events on
        set_cfg(4'd4, 1'b0, 1'b0, 1'b1, "R7");
        run_ticks(50);
        seg_end("R7");
        // R5 R6: override
        set_cfg(4'd4, 1'b0, 1'b1, 1'b1, "R5");
        run_ticks(30);
        seg_end("R6");
        set_cfg(4'd0, 1'b1, 1'b1, 1'b1, "R5");
        run_ticks(10);
        seg_end("R5");
        // R9: change code in mid period
        set_cfg(4'd5, 1'b1, 1'b0, 1'b1, "R9");
        run_ticks(11);
        set_cfg(4'd6, 1'b1, 1'b0, 1'b1, "R9");
        run_ticks(40);
        seg_end("R9");
        set_cfg(4'd3, 1'b1, 1'b0, 1'b1, "R9");
        run_ticks(1);
        set_cfg(4'd4, 1'b1, 1'b0, 1'b1, "R9");
        run_ticks(12);
        seg_end("R9");

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule